// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer for a system-on-chip. A 32-bit register port sets it up, and one clock drives both the port and the timer. Software picks a clock divider and a coarse timeout, then arms the timer. After that, software must write a fixed magic word to a restart register at intervals. If no restart arrives before the down-counter reaches zero, the block flags a timeout. It can report the timeout as a level interrupt, as a reset pulse of selectable length, or both.

Each configuration register has its own 12-bit key field. A write whose key field holds any other value is dropped without effect. A restart write whose word differs from the magic value is also dropped. A stray store to the block therefore cannot disarm the timer or feed it. The 12-bit timeout field sets the upper bits of the down-counter, and the lower bits always reload as ones.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, every register reads as zero, the timer is disabled, and `irq_o` and `rst_o` are low.
- R2: A write to byte offset 0x0 is accepted only when `reg_wdata[23:12]` equals 0xABC. It stores the run enable in bit 0, the reset-output enable in bit 1, the interrupt enable in bit 2 and the pulse-length code in bits [5:4]. A read returns only these bits. A write with a wrong key leaves the register unchanged.
- R3: A write to offset 0x4 is accepted only when `reg_wdata[25:14]` equals 0x248. It stores the 12-bit timeout field in bits [13:2] and the divider code in bits [1:0]. A read returns only these bits. A write with a wrong key leaves the register unchanged.
- R4: Writing exactly 0x00001999 to offset 0x8 reloads the counter and the divider and clears the timeout flag. Any other word written there has no effect. While restarts keep arriving in time, no timeout occurs.
- R5: Divider codes 0, 1, 2 and 3 give one counter step every 8, 64, 512 and 4096 clocks. The counter reloads to T·2^LOW_BITS + 2^LOW_BITS − 1, where T is the timeout field. The timeout flag sets N·D + 1 clock edges after the edge that accepted the restart or the enable, where N is that reload value and D is the divider.
- R6: While the run enable is clear, the divider and counter are held at their reload values and no timeout can happen. Setting the enable then starts a full timeout period.
- R7: Bit 0 at offset 0xC reads the timeout flag. Once set, it stays set until a valid restart. Writes to 0xC are ignored.
- R8: `irq_o` is high exactly while the timeout flag is set and the interrupt enable is set.
- R9: If the reset-output enable is set when the timeout occurs, `rst_o` goes high for 2, 4, 8 or 16 clocks, for pulse-length codes 0, 1, 2 and 3. The pulse starts in the same cycle the flag sets. There is one pulse per timeout.
- R10: With both output enables clear, a timeout still sets the flag, but `irq_o` and `rst_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port and the timer |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 4 | Byte address; only word-aligned offsets 0x0 to 0xC hit a register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Timeout interrupt level |
| rst_o | output | 1 | Timeout reset pulse, active high |

## Verification
Wrong counter or divider state has no effect on the register port. It shows up only as a timeout edge on `irq_o` or `rst_o` that arrives early or late, so the bench measures the exact edge count from the arming write for every divider code. A key check that is too loose shows up at once in the next readback of the configuration register. A flag that fails to stay set, or a pulse counter that is off, shows within a few clocks as a wrong `rst_o` width or a wrong status read. A counter that does not hold while disabled shows up one full timeout period later, as an early interrupt after re-enabling.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CRV_W  = 12;
  localparam int unsigned PRE_W  = 12;
  localparam int unsigned PLS_W  = 5;

  localparam logic [11:0] ZMODE_KEY = 12'hABC;
  localparam logic [11:0] CCTL_KEY  = 12'h248;
  localparam logic [31:0] KICK_WORD = 32'h0000_1999;

  typedef enum logic [1:0] {
    REG_ZMODE = 2'd0,
    REG_CCTL  = 2'd1,
    REG_KICK  = 2'd2,
    REG_STAT  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [1:0] plen;
    logic       irq_en;
    logic       rst_en;
    logic       run;
  } zmode_t;

  typedef struct packed {
    logic [CRV_W-1:0] crv;
    logic [1:0]       psel;
  } cctl_t;

  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
    logic [PRE_W-1:0] lim;
    case (sel)
      2'd0:    lim = 12'd7;
      2'd1:    lim = 12'd63;
      2'd2:    lim = 12'd511;
      default: lim = 12'd4095;
    endcase
    return lim;
  endfunction

  function automatic logic [PLS_W-1:0] pulse_len(input logic [1:0] code);
    return PLS_W'(5'd2 << code);
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              stat,
  output zmode_t            zmode,
  output cctl_t             cctl,
  output logic              kick,
  output logic [31:0]       reg_rdata
);

  reg_sel_e sel;
  logic     aligned;
  logic     zm_we;
  logic     cc_we;
  zmode_t   zm_d, zm_q;
  cctl_t    cc_d, cc_q;

  assign sel     = reg_sel_e'(reg_addr[3:2]);
  assign aligned = (reg_addr[1:0] == 2'b00);

  assign zm_we = reg_wr && aligned && (sel == REG_ZMODE) &&
                 (reg_wdata[23:12] == ZMODE_KEY);
  assign cc_we = reg_wr && aligned && (sel == REG_CCTL) &&
                 (reg_wdata[25:14] == CCTL_KEY);
  assign kick  = reg_wr && aligned && (sel == REG_KICK) &&
                 (reg_wdata == KICK_WORD);

  always_comb begin
    zm_d = zm_q;
    if (zm_we) begin
      zm_d.run    = reg_wdata[0];
      zm_d.rst_en = reg_wdata[1];
      zm_d.irq_en = reg_wdata[2];
      zm_d.plen   = reg_wdata[5:4];
    end
  end

  always_comb begin
    cc_d = cc_q;
    if (cc_we) begin
      cc_d.crv  = reg_wdata[13:2];
      cc_d.psel = reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zm_q <= '0;
      cc_q <= '0;
    end else begin
      zm_q <= zm_d;
      cc_q <= cc_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      case (sel)
        REG_ZMODE: reg_rdata = {26'b0, zm_q.plen, 1'b0, zm_q.irq_en, zm_q.rst_en, zm_q.run};
        REG_CCTL:  reg_rdata = {18'b0, cc_q.crv, cc_q.psel};
        REG_STAT:  reg_rdata = {31'b0, stat};
        default:   reg_rdata = '0;
      endcase
    end
  end

  assign zmode = zm_q;
  assign cctl  = cc_q;

  AST_ZMODE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == 4'h0) && (reg_wdata[23:12] != ZMODE_KEY)) |=> $stable(zm_q)); // R2

  AST_CCTL_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == 4'h4) && (reg_wdata[25:14] != CCTL_KEY)) |=> $stable(cc_q)); // R3

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       kick,
  input  logic [1:0] psel,
  output logic       tick
);

  logic [PRE_W-1:0] pre_d, pre_q;
  logic [PRE_W-1:0] limit;

  assign limit = pre_limit(psel);
  assign tick  = run && !kick && (pre_q == limit);

  always_comb begin
    pre_d = pre_q;
    if (!run || kick || tick) pre_d = '0;
    else                      pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R5

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick); // R6

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned LOW_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             kick,
  input  logic             tick,
  input  logic [CRV_W-1:0] crv,
  output logic             at_zero
);

  localparam int unsigned CNT_W = CRV_W + LOW_BITS;

  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt_d, cnt_q;

  assign reload  = {crv, {LOW_BITS{1'b1}}};
  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || kick)           cnt_d = reload;
    else if (tick && !at_zero)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= {CRV_W'(0), {LOW_BITS{1'b1}}};
    else        cnt_q <= cnt_d;
  end

  AST_NO_RELOAD_WITHOUT_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !kick) |=> (cnt_q <= $past(cnt_q))); // R4

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == $past(reload))); // R6

endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       kick,
  input  logic       at_zero,
  input  logic       irq_en,
  input  logic       rst_en,
  input  logic [1:0] plen,
  output logic       stat,
  output logic       irq_o,
  output logic       rst_o
);

  logic             fire;
  logic             stat_d, stat_q;
  logic [PLS_W-1:0] pls_d, pls_q;

  assign fire = run && at_zero && !stat_q && !kick;

  always_comb begin
    stat_d = stat_q;
    if (kick)      stat_d = 1'b0;
    else if (fire) stat_d = 1'b1;
  end

  always_comb begin
    pls_d = pls_q;
    if (fire && rst_en)     pls_d = pulse_len(plen);
    else if (pls_q != '0)   pls_d = pls_q - PLS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      pls_q  <= '0;
    end else begin
      stat_q <= stat_d;
      pls_q  <= pls_d;
    end
  end

  assign stat  = stat_q;
  assign irq_o = stat_q && irq_en;
  assign rst_o = (pls_q != '0);

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !kick) |=> stat_q); // R7

  AST_PULSE_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> $past(fire)); // R9

  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_en && !rst_o) |=> !rst_o); // R10

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned LOW_BITS    = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_o,
  output logic        rst_o
);

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   srst_n;
  zmode_t                 zmode;
  cctl_t                  cctl;
  logic                   kick;
  logic                   tick;
  logic                   at_zero;
  logic                   stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = rst_sync[SYNC_STAGES-1];

  wdt_regs u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .stat      (stat),
    .zmode     (zmode),
    .cctl      (cctl),
    .kick      (kick),
    .reg_rdata (reg_rdata)
  );

  wdt_prescaler u_pre (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (zmode.run),
    .kick  (kick),
    .psel  (cctl.psel),
    .tick  (tick)
  );

  wdt_counter #(.LOW_BITS(LOW_BITS)) u_cnt (
    .clk     (clk),
    .rst_n   (srst_n),
    .run     (zmode.run),
    .kick    (kick),
    .tick    (tick),
    .crv     (cctl.crv),
    .at_zero (at_zero)
  );

  wdt_timeout u_tmo (
    .clk     (clk),
    .rst_n   (srst_n),
    .run     (zmode.run),
    .kick    (kick),
    .at_zero (at_zero),
    .irq_en  (zmode.irq_en),
    .rst_en  (zmode.rst_en),
    .plen    (zmode.plen),
    .stat    (stat),
    .irq_o   (irq_o),
    .rst_o   (rst_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !srst_n |-> (!irq_o && !rst_o)); // R1

endmodule

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;

  localparam int unsigned LOWB = 2;
  localparam logic [31:0] ZK   = 32'h00AB_C000;
  localparam logic [31:0] CK   = 32'h0092_0000;
  localparam logic [31:0] KICK = 32'h0000_1999;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  logic        rst_o;

  int total = 0;
  int bad   = 0;

  logic [31:0] exp_q[$];
  string       req_q[$];
  logic        rd_chk = 1'b0;

  always #2 clk = ~clk;

  keyed_wdt #(.LOW_BITS(LOWB)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .rst_o     (rst_o)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // monitor: pops the expected read values pushed by the driver
  always @(negedge clk) begin
    if (rd_chk) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 1, 0);
      end else begin
        check(req_q.pop_front(), int'(reg_rdata), int'(exp_q.pop_front()));
      end
    end
  end

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [31:0] e, input string req);
    @(posedge clk); #1;
    reg_addr = a; rd_chk = 1'b1;
    exp_q.push_back(e); req_q.push_back(req);
    @(posedge clk); #1;
    rd_chk = 1'b0;
  endtask

  task automatic measure(input int limit, output int t_irq, output int t_rst, output int rst_w);
    t_irq = -1; t_rst = -1; rst_w = 0;
    for (int n = 1; n <= limit; n++) begin
      @(posedge clk); #1;
      if (irq_o && t_irq < 0) t_irq = n;
      if (rst_o) begin
        if (t_rst < 0) t_rst = n;
        rst_w++;
      end
    end
  endtask

  task automatic arm(input logic [31:0] zf, input int crv, input int psel);
    wr_reg(4'h0, ZK);
    wr_reg(4'h4, CK | 32'(crv << 2) | 32'(psel));
    wr_reg(4'h0, ZK | zf | 32'h1);
    wr_reg(4'h8, KICK);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ti, tr, rw;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 irq_o after reset", int'(irq_o), 0);
    check("R1 rst_o after reset", int'(rst_o), 0);
    rd_exp(4'h0, 32'h0, "R1 zero-mode reset");
    rd_exp(4'h4, 32'h0, "R1 counter-control reset");
    rd_exp(4'hC, 32'h0, "R1 status reset");

    // R2 keyed zero-mode register
    wr_reg(4'h0, ZK | 32'h26);
    rd_exp(4'h0, 32'h26, "R2 good key stored");
    wr_reg(4'h0, 32'h00AB_D001);
    rd_exp(4'h0, 32'h26, "R2 bad key ignored");

    // R3 keyed counter-control register
    wr_reg(4'h4, CK | (32'hA5C << 2) | 32'h2);
    rd_exp(4'h4, 32'h2972, "R3 good key stored");
    wr_reg(4'h4, 32'h0093_0003);
    rd_exp(4'h4, 32'h2972, "R3 bad key ignored");

    // R5/R8: divide by 8, field 1 -> N=7, timeout at 7*8+1
    arm(32'h4, 1, 0);
    measure(80, ti, tr, rw);
    check("R5 div8 timeout edge", ti, 57);
    check("R9 no pulse without reset enable", rw, 0);
    rd_exp(4'hC, 32'h1, "R7 status set");
    wr_reg(4'h8, 32'h0000_1998);
    rd_exp(4'hC, 32'h1, "R4 wrong restart word ignored");
    check("R8 irq follows status", int'(irq_o), 1);
    wr_reg(4'hC, 32'h0);
    rd_exp(4'hC, 32'h1, "R7 status write ignored");
    wr_reg(4'h8, KICK);
    rd_exp(4'hC, 32'h0, "R4 restart clears status");
    check("R8 irq low after restart", int'(irq_o), 0);
    for (int k = 0; k < 5; k++) begin
      repeat (40) @(posedge clk);
      wr_reg(4'h8, KICK);
    end
    check("R4 regular restarts keep irq low", int'(irq_o), 0);
    rd_exp(4'hC, 32'h0, "R4 regular restarts keep status clear");

    // R9: divide by 64, field 0 -> N=3, pulse code 1 (4 clocks)
    arm(32'h12, 0, 1);
    measure(220, ti, tr, rw);
    check("R5 div64 timeout edge", tr, 193);
    check("R9 pulse width code1", rw, 4);
    check("R8 irq masked", ti, -1);
    measure(300, ti, tr, rw);
    check("R9 single pulse per timeout", rw, 0);

    // divide by 512, pulse code 3 (16 clocks), both outputs
    arm(32'h36, 0, 2);
    measure(1560, ti, tr, rw);
    check("R5 div512 irq edge", ti, 1537);
    check("R9 div512 pulse start", tr, 1537);
    check("R9 pulse width code3", rw, 16);

    // divide by 4096, pulse code 0 (2 clocks)
    arm(32'h2, 0, 3);
    measure(12300, ti, tr, rw);
    check("R5 div4096 timeout edge", tr, 12289);
    check("R9 pulse width code0", rw, 2);

    // R10: no outputs enabled
    arm(32'h0, 0, 0);
    measure(60, ti, tr, rw);
    check("R10 irq stays low", ti, -1);
    check("R10 rst stays low", rw, 0);
    rd_exp(4'hC, 32'h1, "R10 status still sets");

    // R6: disabled holds the counter
    arm(32'h4, 0, 0);
    wr_reg(4'h0, ZK | 32'h4);
    measure(200, ti, tr, rw);
    check("R6 no timeout while disabled", ti, -1);
    rd_exp(4'hC, 32'h0, "R6 status clear while disabled");
    wr_reg(4'h0, ZK | 32'h5);
    measure(40, ti, tr, rw);
    check("R6 full period after enable", ti, 25);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule